// File: doc/BRIEF.md
# Variable-Rate Cubic CIC Interpolator

This block raises the sample rate of one signed sample stream by a run-time programmable integer factor. Samples arrive through a valid/ready handshake, at most one per input period. Results leave on every pulse of an output clock enable. An input period is a fixed number of output enables. Three difference stages run at the input rate. A zero-order hold follows them, and three accumulator stages run at the output rate. The DC gain of this chain is the cube of the rate factor. A programmable arithmetic right shift scales that gain back down, and the result is saturated to the output width.

The rate factor is written as a small floating-point code: a mantissa shifted left by an exponent. The new rate and shift are first written into staging registers. They take effect only when an apply strobe arrives with this channel's bit set in its channel mask. Applying a configuration does three things: it clears all filter state, it restarts the input-period phase at that cycle, and it mutes output updates until three fresh samples have been taken. When the gain changes, the output may jump; this step is expected.

Top module: `cic_interp`

## Requirements
- R1: After reset, the active rate is 1 and the active shift is 0. `in_ready` is 1, `out_data` is 0 and `out_upd` is 0.
- R2: Staging writes have no effect on their own. An apply changes the active setting only if `apply_mask[CH]` is 1; other mask bits are ignored. An apply uses the staged values held before its own cycle.
- R3: The rate is R = `stage_mant` << `stage_exp`. An apply is ignored entirely when the mantissa is 0 or R > 65536; the filter is not cleared in that case. R = 65536 (mantissa 2, exponent 15) is accepted.
- R4: An input period is R pulses of `out_ce`. The period boundary is the `out_ce` at phase R-1. After a handshake, `in_ready` stays 0 until the next boundary, so at most one sample is accepted per period (two if one lands on the boundary cycle).
- R5: A valid apply clears the phase, the hold register and all filter stages. `in_ready` is 1 in the next cycle, and the next boundary comes R `out_ce` pulses later.
- R6: After reset or a valid apply, `out_upd` stays 0 until three samples have been accepted.
- R7: The filter is three input-rate differences, then a zero-order hold, then three output-rate accumulators. It uses 64-bit wraparound arithmetic. For a constant input x, the settled output is (x·R³) >>> shift. This gives x exactly when R = 2^k and shift = 3k.
- R8: After the shift, the value is saturated to the signed 16-bit range [-32768, 32767].
- R9: Once settled, `out_upd` pulses in the cycle after each `out_ce` that is not in an apply cycle. `out_data` changes only together with `out_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_we | input | 1 | Load the staging registers |
| stage_mant | input | 6 | Staged rate mantissa |
| stage_exp | input | 4 | Staged rate exponent |
| stage_gain | input | 6 | Staged right-shift amount |
| apply | input | 1 | Commit strobe |
| apply_mask | input | 4 | Channel select for the commit |
| out_ce | input | 1 | Output sample enable |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Sample can be accepted |
| out_data | output | 16 | Signed output sample |
| out_upd | output | 1 | Output updated this cycle |

## Verification
The bench targets the boundary between input periods. A phase counter that is off by one would let two samples through in one period, or reopen `in_ready` one enable early. It checks rate codes at the edges: a zero mantissa, a rate just above 65536 and exactly 65536. A wrong validity test would either break the filter with a bad rate or reject the largest legal one. It also checks the three-sample mute after an apply and the saturation at both rails. An apply that failed to clear the state would leak old filter contents. Without saturation, the output would wrap to the opposite sign.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_ORDER    = 3;
  localparam int CIC_DW       = 16;
  localparam int CIC_GROWTH   = 48;
  localparam int CIC_MANT_W   = 6;
  localparam int CIC_EXP_W    = 4;
  localparam int CIC_GAIN_W   = 6;
  localparam int CIC_MAX_RATE = 65536;
endpackage

// File: rtl/cic_cfg.sv
module cic_cfg #(
  parameter int MANT_W   = cic_pkg::CIC_MANT_W,
  parameter int EXP_W    = cic_pkg::CIC_EXP_W,
  parameter int GAIN_W   = cic_pkg::CIC_GAIN_W,
  parameter int NCH      = 4,
  parameter int CH       = 0,
  parameter int MAX_RATE = cic_pkg::CIC_MAX_RATE,
  parameter int RW       = $clog2(MAX_RATE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic [MANT_W-1:0] stage_mant,
  input  logic [EXP_W-1:0]  stage_exp,
  input  logic [GAIN_W-1:0] stage_gain,
  input  logic              apply,
  input  logic [NCH-1:0]    apply_mask,
  output logic              commit,
  output logic [RW-1:0]     act_rate,
  output logic [GAIN_W-1:0] act_gain
);
  localparam int RAW_W = MANT_W + (1 << EXP_W) - 1;

  logic [MANT_W-1:0] mant_q, mant_d;
  logic [EXP_W-1:0]  exp_q, exp_d;
  logic [GAIN_W-1:0] gain_q, gain_d, agn_d;
  logic [RW-1:0]     rate_d;
  logic [RAW_W-1:0]  raw;
  logic              code_ok;

  always_comb begin
    raw     = RAW_W'(mant_q) << exp_q;
    code_ok = (mant_q != '0) && (raw <= RAW_W'(MAX_RATE));
    commit  = apply && apply_mask[CH] && code_ok;
    mant_d  = stage_we ? stage_mant : mant_q;
    exp_d   = stage_we ? stage_exp  : exp_q;
    gain_d  = stage_we ? stage_gain : gain_q;
    rate_d  = commit ? RW'(raw) : act_rate;
    agn_d   = commit ? gain_q   : act_gain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q   <= MANT_W'(1);
      exp_q    <= '0;
      gain_q   <= '0;
      act_rate <= RW'(1);
      act_gain <= '0;
    end else begin
      mant_q   <= mant_d;
      exp_q    <= exp_d;
      gain_q   <= gain_d;
      act_rate <= rate_d;
      act_gain <= agn_d;
    end
  end
endmodule

// File: rtl/cic_timing.sv
module cic_timing #(
  parameter int N  = cic_pkg::CIC_ORDER,
  parameter int RW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          out_ce,
  input  logic          in_valid,
  input  logic [RW-1:0] act_rate,
  output logic          in_ready,
  output logic          fire,
  output logic          boundary,
  output logic          settled
);
  localparam int SW = $clog2(N + 1);
  localparam logic [SW-1:0] SETTLE_N = SW'(N);

  logic [RW-1:0] ph_q, ph_d;
  logic          taken_q, taken_d;
  logic [SW-1:0] settle_q, settle_d;

  always_comb begin
    in_ready = !taken_q;
    fire     = in_valid && !taken_q;
    boundary = out_ce && (ph_q == act_rate - RW'(1));
    settled  = (settle_q == '0);
    ph_d     = ph_q;
    taken_d  = taken_q;
    settle_d = settle_q;
    if (commit) begin
      ph_d     = '0;
      taken_d  = 1'b0;
      settle_d = SETTLE_N;
    end else begin
      if (out_ce) ph_d = boundary ? '0 : ph_q + RW'(1);
      if (boundary) taken_d = 1'b0;
      else if (fire) taken_d = 1'b1;
      if (fire && !settled) settle_d = settle_q - SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      taken_q  <= 1'b0;
      settle_q <= SETTLE_N;
    end else begin
      ph_q     <= ph_d;
      taken_q  <= taken_d;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int N  = cic_pkg::CIC_ORDER,
  parameter int DW = cic_pkg::CIC_DW,
  parameter int IW = DW + cic_pkg::CIC_GROWTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          fire,
  input  logic          boundary,
  input  logic [DW-1:0] in_data,
  output logic [IW-1:0] c_out
);
  logic [DW-1:0] hold_q, hold_d;
  logic [IW-1:0] dif [N+1];
  logic [IW-1:0] z_q [N];
  logic [IW-1:0] c_d;
  logic          step;

  always_comb begin
    step   = boundary && !commit;
    hold_d = commit ? '0 : (fire ? in_data : hold_q);
    dif[0] = {{(IW-DW){hold_q[DW-1]}}, hold_q};
    c_d    = commit ? '0 : (step ? dif[N] : c_out);
  end

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic [IW-1:0] z_d;
    always_comb begin
      dif[k+1] = dif[k] - z_q[k];
      z_d      = commit ? '0 : (step ? dif[k] : z_q[k]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_q[k] <= '0;
      else        z_q[k] <= z_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      c_out  <= '0;
    end else begin
      hold_q <= hold_d;
      c_out  <= c_d;
    end
  end
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int N  = cic_pkg::CIC_ORDER,
  parameter int IW = cic_pkg::CIC_DW + cic_pkg::CIC_GROWTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          out_ce,
  input  logic [IW-1:0] u,
  output logic [IW-1:0] acc_next
);
  logic [IW-1:0] sum [N+1];
  logic [IW-1:0] i_q [N];

  assign sum[0]   = u;
  assign acc_next = sum[N];

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic [IW-1:0] i_d;
    always_comb begin
      sum[k+1] = i_q[k] + sum[k];
      i_d      = commit ? '0 : (out_ce ? sum[k+1] : i_q[k]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) i_q[k] <= '0;
      else        i_q[k] <= i_d;
    end
  end
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
  parameter int N        = cic_pkg::CIC_ORDER,
  parameter int DW       = cic_pkg::CIC_DW,
  parameter int OW       = cic_pkg::CIC_DW,
  parameter int GROWTH   = cic_pkg::CIC_GROWTH,
  parameter int MANT_W   = cic_pkg::CIC_MANT_W,
  parameter int EXP_W    = cic_pkg::CIC_EXP_W,
  parameter int GAIN_W   = cic_pkg::CIC_GAIN_W,
  parameter int MAX_RATE = cic_pkg::CIC_MAX_RATE,
  parameter int NCH      = 4,
  parameter int CH       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic [MANT_W-1:0] stage_mant,
  input  logic [EXP_W-1:0]  stage_exp,
  input  logic [GAIN_W-1:0] stage_gain,
  input  logic              apply,
  input  logic [NCH-1:0]    apply_mask,
  input  logic              out_ce,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic [OW-1:0]     out_data,
  output logic              out_upd
);
  localparam int IW = DW + GROWTH;
  localparam int RW = $clog2(MAX_RATE) + 1;
  localparam logic signed [IW-1:0] OMAX = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] OMIN = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic              commit, fire, boundary, settled;
  logic [RW-1:0]     act_rate;
  logic [GAIN_W-1:0] act_gain;
  logic [IW-1:0]     c_out, acc_next;
  logic signed [IW-1:0] shifted;
  logic [OW-1:0]     sat_v, out_d;
  logic              upd_d;

  cic_cfg #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .GAIN_W(GAIN_W), .NCH(NCH), .CH(CH),
    .MAX_RATE(MAX_RATE), .RW(RW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_mant(stage_mant),
    .stage_exp(stage_exp), .stage_gain(stage_gain), .apply(apply),
    .apply_mask(apply_mask), .commit(commit), .act_rate(act_rate),
    .act_gain(act_gain)
  );

  cic_timing #(.N(N), .RW(RW)) u_timing (
    .clk(clk), .rst_n(rst_n), .commit(commit), .out_ce(out_ce),
    .in_valid(in_valid), .act_rate(act_rate), .in_ready(in_ready),
    .fire(fire), .boundary(boundary), .settled(settled)
  );

  cic_comb #(.N(N), .DW(DW), .IW(IW)) u_comb (
    .clk(clk), .rst_n(rst_n), .commit(commit), .fire(fire),
    .boundary(boundary), .in_data(in_data), .c_out(c_out)
  );

  cic_integ #(.N(N), .IW(IW)) u_integ (
    .clk(clk), .rst_n(rst_n), .commit(commit), .out_ce(out_ce),
    .u(c_out), .acc_next(acc_next)
  );

  always_comb begin
    shifted = $signed(acc_next) >>> act_gain;
    if (shifted > OMAX)      sat_v = OMAX[OW-1:0];
    else if (shifted < OMIN) sat_v = OMIN[OW-1:0];
    else                     sat_v = shifted[OW-1:0];
    upd_d = out_ce && settled && !commit;
    out_d = upd_d ? sat_v : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_upd  <= 1'b0;
    end else begin
      out_data <= out_d;
      out_upd  <= upd_d;
    end
  end
endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_ce,
  input logic          out_upd,
  input logic          commit,
  input logic          boundary,
  input logic [OW-1:0] out_data
);
  // R4
  one_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !commit && !boundary) |=> !in_ready);
  // R4
  ready_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ce && !commit) |=> !in_ready);
  // R5
  apply_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> in_ready);
  // R6
  apply_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !out_upd);
  // R9
  upd_follows_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_upd |-> $past(out_ce));
  // R9
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_upd |-> $stable(out_data));
endmodule

bind cic_interp cic_interp_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_ce(out_ce), .out_upd(out_upd), .commit(commit), .boundary(boundary),
  .out_data(out_data)
);

// File: tb/cic_interp_bench.sv
module cic_interp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stage_we = 1'b0;
  logic [5:0]  stage_mant = '0;
  logic [3:0]  stage_exp = '0;
  logic [5:0]  stage_gain = '0;
  logic        apply = 1'b0;
  logic [3:0]  apply_mask = '0;
  logic        out_ce = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic [15:0] out_data;
  logic        out_upd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cic_interp u_cic_interp (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_mant(stage_mant),
    .stage_exp(stage_exp), .stage_gain(stage_gain), .apply(apply),
    .apply_mask(apply_mask), .out_ce(out_ce), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_data(out_data),
    .out_upd(out_upd)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  longint m_rate, m_gain, s_mant, s_exp, s_gain, m_ph, m_settle;
  bit     m_taken, m_upd, m_started;
  longint m_hold, m_c;
  longint mz [3];
  longint mi [3];
  logic [15:0] m_out;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    longint raw, a1, a2, a3, d1, d2, d3, sh;
    bit commit, bnd, fire, valid;
    if (!rst_n) begin
      m_rate = 1; m_gain = 0; s_mant = 1; s_exp = 0; s_gain = 0;
      m_ph = 0; m_settle = 3; m_taken = 0; m_upd = 0; m_hold = 0; m_c = 0;
      for (int k = 0; k < 3; k++) begin mz[k] = 0; mi[k] = 0; end
      m_out = '0;
    end else begin
      raw    = s_mant << s_exp;
      valid  = (s_mant != 0) && (raw <= 65536);
      commit = apply && apply_mask[0] && valid;
      bnd    = out_ce && (m_ph == m_rate - 1);
      fire   = in_valid && !m_taken;
      a1 = mi[0] + m_c; a2 = mi[1] + a1; a3 = mi[2] + a2;
      d1 = m_hold - mz[0]; d2 = d1 - mz[1]; d3 = d2 - mz[2];
      if (commit) begin
        m_rate = raw; m_gain = s_gain;
        m_ph = 0; m_taken = 0; m_settle = 3; m_hold = 0; m_c = 0; m_upd = 0;
        for (int k = 0; k < 3; k++) begin mz[k] = 0; mi[k] = 0; end
      end else begin
        m_upd = out_ce && (m_settle == 0);
        if (m_upd) begin
          sh = a3 >>> m_gain;
          if (sh > 32767) sh = 32767;
          if (sh < -32768) sh = -32768;
          m_out = 16'(sh);
        end
        if (out_ce) begin mi[0] = a1; mi[1] = a2; mi[2] = a3; end
        if (bnd) begin mz[2] = d2; mz[1] = d1; mz[0] = m_hold; m_c = d3; end
        if (fire && m_settle != 0) m_settle--;
        if (fire) m_hold = longint'($signed(in_data));
        if (out_ce) m_ph = bnd ? 0 : m_ph + 1;
        if (bnd) m_taken = 0; else if (fire) m_taken = 1;
      end
      if (stage_we) begin s_mant = stage_mant; s_exp = stage_exp; s_gain = stage_gain; end
    end
    m_started = 1;
    #3;
    check(in_ready === !m_taken, "R4 in_ready vs model", in_ready, !m_taken);
    check(out_upd === m_upd, "R9 out_upd vs model", out_upd, m_upd);
    check(out_data === m_out, "R7 out_data vs model", $signed(out_data), $signed(m_out));
  end

  task automatic stage(input int mant, input int ex, input int g);
    @(negedge clk);
    stage_we = 1; stage_mant = 6'(mant); stage_exp = 4'(ex); stage_gain = 6'(g);
    @(negedge clk);
    stage_we = 0;
  endtask

  task automatic do_apply(input logic [3:0] m);
    @(negedge clk);
    apply = 1; apply_mask = m;
    @(negedge clk);
    apply = 0; apply_mask = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_ready(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (in_ready) c++;
      @(negedge clk);
    end
  endtask

  initial begin
    int c, u;
    logic [15:0] held;
    run(3);
    rst_n = 1;
    // R1 reset state
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(out_data === 16'd0, "R1 out_data after reset", out_data, 0);
    check(out_upd === 1'b0, "R1 out_upd after reset", out_upd, 0);
    out_ce = 1;
    // R1: rate 1 means ready every cycle while valid low
    count_ready(8, c);
    check(c == 8, "R1 rate one", c, 8);

    // R7 unity gain for rate 4 shift 6
    stage(1, 2, 6);
    do_apply(4'b0001);
    // R6 no updates before three samples
    in_valid = 0;
    u = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (out_upd) u++; end
    check(u == 0, "R6 muted before three samples", u, 0);
    in_valid = 1; in_data = 16'd1000;
    run(100);
    check($signed(out_data) == 1000, "R7 unity DC rate 4", $signed(out_data), 1000);

    // R7 non power of two: rate 3 shift 5 gives 27/32
    stage(3, 0, 5);
    do_apply(4'b0001);
    run(100);
    check($signed(out_data) == 843, "R7 DC rate 3", $signed(out_data), 843);

    // R8 saturation both rails
    stage(1, 2, 0);
    do_apply(4'b0001);
    run(100);
    check($signed(out_data) == 32767, "R8 positive rail", $signed(out_data), 32767);
    in_data = -16'sd1000;
    run(100);
    check($signed(out_data) == -32768, "R8 negative rail", $signed(out_data), -32768);

    // R4 one sample per period at rate 8
    in_data = 16'd50;
    stage(1, 3, 9);
    do_apply(4'b0001);
    count_ready(32, c);
    check(c == 4, "R4 one accept per period", c, 4);

    // R2 staging alone and foreign mask bit do nothing
    stage(1, 1, 3);
    count_ready(32, c);
    check(c == 4, "R2 staging without apply", c, 4);
    do_apply(4'b0010);
    count_ready(32, c);
    check(c == 4, "R2 foreign mask ignored", c, 4);
    do_apply(4'b0001);
    count_ready(32, c);
    check(c == 16, "R2 own mask applies", c, 16);

    // R3 invalid codes rejected
    stage(0, 3, 0);
    do_apply(4'b0001);
    count_ready(32, c);
    check(c == 16, "R3 zero mantissa ignored", c, 16);
    stage(33, 11, 0);
    do_apply(4'b0001);
    count_ready(32, c);
    check(c == 16, "R3 rate above 65536 ignored", c, 16);

    // R9 no output enable means no update and stable data
    out_ce = 0;
    @(negedge clk);
    held = out_data;
    u = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (out_upd) u++; end
    check(u == 0, "R9 no update without out_ce", u, 0);
    check(out_data === held, "R9 data stable", out_data, held);
    out_ce = 1;

    // R5 apply mid-period realigns and reopens ready
    stage(1, 3, 9);
    do_apply(4'b0001);
    run(3);
    check(in_ready === 1'b0, "R5 ready low mid-period", in_ready, 0);
    do_apply(4'b0001);
    check(in_ready === 1'b1, "R5 ready after apply", in_ready, 1);
    count_ready(16, c);
    check(c == 2, "R5 period restarted", c, 2);

    // R3 largest rate accepted
    stage(2, 15, 48);
    do_apply(4'b0001);
    count_ready(65540, c);
    check(c == 2, "R3 rate 65536 accepted", c, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule